// File: doc/BRIEF.md
# CEC Receive Error-Bit Policy Unit

This block sits behind the bit decoder of a CEC receiver. It receives one-cycle strobes for three timing faults: a rising edge that comes at the wrong time (rise fault), a bit period that is too long (long fault) and a bit period that is too short (short fault). For each accepted fault it decides two things. The first is whether the frame in progress is abandoned. The second is whether the receiver pulls the bus low for an error bit so that the other devices learn of the fault. It also keeps one sticky flag per fault kind.

The decision depends on the frame type (directed or broadcast) and on the listening mode. It also depends on four configuration bits: stop on a rise fault, error bit on a rise fault, error bit on a long fault, and silence on broadcast. Broadcast frames follow their own rules, which override the per-fault error-bit enables. After an abort, the unit holds the receiver off for the rest of the frame. It ignores further strobes until its own error bit has ended and the bus has been seen high for one full bit period. All pins are plain control and status signals. No data passes through the block, so it has no valid/ready handshake.

Top module: `cec_rx_errpol`

## Requirements
- R1: A rise fault aborts reception (one-cycle `rx_abort_o`, in the cycle after the strobe) only when `cfg_stop_on_rise_i` is 1. An accepted long or short fault always aborts.
- R2: On a directed frame (`bcast_i`=0), a rise fault requests an error bit exactly when both `cfg_rise_errbit_i` and `cfg_stop_on_rise_i` are 1.
- R3: On a directed frame, a long fault requests an error bit exactly when `cfg_long_errbit_i` is 1.
- R4: On a broadcast frame with `cfg_bcast_quiet_i`=0, a rise fault requests an error bit whenever `cfg_stop_on_rise_i` is 1, whatever the value of `cfg_rise_errbit_i`. A long fault always requests one, whatever the value of `cfg_long_errbit_i`.
- R5: On a broadcast frame with `cfg_bcast_quiet_i`=1, no fault ever produces an error bit.
- R6: A short fault requests an error bit, except on a broadcast frame while `full_listen_i` is 1 (or while the broadcast silence of R5 applies).
- R7: An error bit is `errbit_o`=1 (bus driven low) for exactly ERR_LEN = 3*BIT_CYCLES/2 consecutive cycles. It starts in the same cycle as the abort pulse that goes with it.
- R8: `flags_o` bit 0 = rise, bit 1 = long, bit 2 = short. A bit becomes 1 in the cycle after an accepted strobe of its kind and stays 1. It returns to 0 in the cycle after a 1 on the matching `flag_clr_i` bit. A new strobe in the same cycle wins over the clear.
- R9: `rx_hold_o` rises together with an abort. While it is 1, strobes are ignored (no flag, no abort, no error bit). It falls only after the error bit has ended and `line_i` has then been sampled 1 on BIT_CYCLES consecutive cycles. A 0 on the line restarts that count.
- R10: After reset, `rx_abort_o`, `errbit_o`, `rx_hold_o` and `flags_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rise_err_i | input | 1 | One-cycle strobe: rise fault detected |
| long_err_i | input | 1 | One-cycle strobe: long bit period |
| short_err_i | input | 1 | One-cycle strobe: short bit period |
| bcast_i | input | 1 | Frame in progress is a broadcast frame |
| full_listen_i | input | 1 | Full listening mode active |
| cfg_stop_on_rise_i | input | 1 | Abort reception on a rise fault |
| cfg_rise_errbit_i | input | 1 | Error-bit enable for rise faults |
| cfg_long_errbit_i | input | 1 | Error-bit enable for long faults |
| cfg_bcast_quiet_i | input | 1 | Never send an error bit on broadcast frames |
| line_i | input | 1 | Sampled bus level (1 = idle/high) |
| flag_clr_i | input | 3 | Write-1-to-clear for the sticky flags |
| rx_abort_o | output | 1 | One-cycle pulse: drop the current frame |
| errbit_o | output | 1 | 1 while the bus must be pulled low |
| rx_hold_o | output | 1 | Receiver is held off until the bus is idle |
| flags_o | output | 3 | Sticky fault flags {short, long, rise} |

## Verification
The assertions check the following on every cycle. Every error bit starts together with an abort. An abort is a single-cycle pulse that raises the hold. No abort follows a cycle in which the hold was already set. Every error bit lasts exactly ERR_LEN cycles. A silenced broadcast never starts an error bit. Clearing a flag with no new strobe takes it to 0. The bench sweeps the whole policy space for each fault kind, which only stimulus can cover: 64 configurations by frame type and listening mode. It also checks the exact hold-release timing after an idle line, the restart of that count when the line drops, and that strobes are ignored while the hold is set.

// File: rtl/cec_errpol_pkg.sv
package cec_errpol_pkg;
  localparam int NKIND   = 3;
  localparam int K_RISE  = 0;
  localparam int K_LONG  = 1;
  localparam int K_SHORT = 2;

  typedef struct packed {
    logic stop_on_rise;
    logic rise_errbit;
    logic long_errbit;
    logic bcast_quiet;
    logic full_listen;
  } policy_cfg_t;

  typedef struct packed {
    logic abort;
    logic errbit;
  } action_t;

  // Policy for one fault kind, given frame type and configuration.
  function automatic action_t decide_action(input int kind, input logic bcast,
                                            input policy_cfg_t c);
    action_t a;
    a.abort  = 1'b0;
    a.errbit = 1'b0;
    case (kind)
      K_RISE: begin
        a.abort = c.stop_on_rise;
        if (bcast) a.errbit = c.stop_on_rise & ~c.bcast_quiet;
        else       a.errbit = c.stop_on_rise & c.rise_errbit;
      end
      K_LONG: begin
        a.abort  = 1'b1;
        a.errbit = bcast ? ~c.bcast_quiet : c.long_errbit;
      end
      default: begin
        a.abort  = 1'b1;
        a.errbit = ~(bcast & (c.bcast_quiet | c.full_listen));
      end
    endcase
    return a;
  endfunction
endpackage

// File: rtl/cec_errpol_decide.sv
module cec_errpol_decide
  import cec_errpol_pkg::*;
(
  input  logic [NKIND-1:0] hit_i,
  input  logic             bcast_i,
  input  policy_cfg_t      cfg_i,
  output logic             abort_o,
  output logic             errbit_o
);
  logic [NKIND-1:0] ab_vec;
  logic [NKIND-1:0] eb_vec;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    action_t act;
    assign act       = decide_action(k, bcast_i, cfg_i);
    assign ab_vec[k] = hit_i[k] & act.abort;
    assign eb_vec[k] = hit_i[k] & act.errbit;
  end

  assign abort_o  = |ab_vec;
  assign errbit_o = |eb_vec;
endmodule

// File: rtl/cec_errpol_flags.sv
module cec_errpol_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[k] <= 1'b0;
      else if (set_i[k]) flags_o[k] <= 1'b1;
      else if (clr_i[k]) flags_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/cec_errpol_pulse.sv
module cec_errpol_pulse #(
  parameter int BIT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic drive_o
);
  localparam int ERR_LEN = (BIT_CYCLES * 3) / 2;
  localparam int CW      = $clog2(ERR_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(ERR_LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign drive_o = (cnt_q != '0);
endmodule

// File: rtl/cec_errpol_hold.sv
module cec_errpol_hold #(
  parameter int BIT_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic drive_i,
  input  logic line_i,
  output logic hold_o
);
  localparam int IW = $clog2(BIT_CYCLES + 1);

  logic [IW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      idle_q <= '0;
    end else if (abort_i) begin
      hold_o <= 1'b1;
      idle_q <= '0;
    end else if (hold_o) begin
      if (line_i && !drive_i) begin
        if (idle_q == IW'(BIT_CYCLES - 1)) begin
          hold_o <= 1'b0;
          idle_q <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end else begin
        idle_q <= '0;
      end
    end
  end
endmodule

// File: rtl/cec_rx_errpol.sv
module cec_rx_errpol
  import cec_errpol_pkg::*;
#(
  parameter int BIT_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_err_i,
  input  logic       long_err_i,
  input  logic       short_err_i,
  input  logic       bcast_i,
  input  logic       full_listen_i,
  input  logic       cfg_stop_on_rise_i,
  input  logic       cfg_rise_errbit_i,
  input  logic       cfg_long_errbit_i,
  input  logic       cfg_bcast_quiet_i,
  input  logic       line_i,
  input  logic [2:0] flag_clr_i,
  output logic       rx_abort_o,
  output logic       errbit_o,
  output logic       rx_hold_o,
  output logic [2:0] flags_o
);
  policy_cfg_t      cfg;
  logic [NKIND-1:0] strobes;
  logic [NKIND-1:0] accepted;
  logic             abort_now;
  logic             errbit_now;

  assign cfg = '{stop_on_rise: cfg_stop_on_rise_i, rise_errbit: cfg_rise_errbit_i,
                 long_errbit: cfg_long_errbit_i, bcast_quiet: cfg_bcast_quiet_i,
                 full_listen: full_listen_i};

  assign strobes[K_RISE]  = rise_err_i;
  assign strobes[K_LONG]  = long_err_i;
  assign strobes[K_SHORT] = short_err_i;
  assign accepted         = strobes & {NKIND{~rx_hold_o}};

  cec_errpol_decide u_decide (
    .hit_i   (accepted),
    .bcast_i (bcast_i),
    .cfg_i   (cfg),
    .abort_o (abort_now),
    .errbit_o(errbit_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_abort_o <= 1'b0;
    else         rx_abort_o <= abort_now;
  end

  cec_errpol_pulse #(.BIT_CYCLES(BIT_CYCLES)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(errbit_now),
    .drive_o(errbit_o)
  );

  cec_errpol_hold #(.BIT_CYCLES(BIT_CYCLES)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(abort_now),
    .drive_i(errbit_o),
    .line_i (line_i),
    .hold_o (rx_hold_o)
  );

  cec_errpol_flags #(.N(NKIND)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accepted),
    .clr_i  (flag_clr_i),
    .flags_o(flags_o)
  );
endmodule

// File: rtl/cec_errpol_chk.sv
module cec_errpol_chk #(
  parameter int BIT_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rise_err_i,
  input logic       long_err_i,
  input logic       short_err_i,
  input logic       bcast_i,
  input logic       cfg_bcast_quiet_i,
  input logic [2:0] flag_clr_i,
  input logic       rx_abort_o,
  input logic       errbit_o,
  input logic       rx_hold_o,
  input logic [2:0] flags_o
);
  localparam int ERR_LEN = (BIT_CYCLES * 3) / 2;
  localparam int RW      = $clog2(ERR_LEN + 2);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (errbit_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  a_r7_errbit_with_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(errbit_o) |-> rx_abort_o);

  a_r7_errbit_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(errbit_o) |-> run_q == RW'(ERR_LEN));

  a_r1_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_abort_o |=> !rx_abort_o);

  a_r9_abort_sets_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_abort_o |-> rx_hold_o);

  a_r9_no_abort_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_hold_o |=> !rx_abort_o);

  a_r5_quiet_broadcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_i && cfg_bcast_quiet_i) |=> !$rose(errbit_o));

  a_r8_clear_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i[0] && !rise_err_i) |=> !flags_o[0]);

  a_r8_clear_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i[1] && !long_err_i) |=> !flags_o[1]);

  a_r8_clear_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i[2] && !short_err_i) |=> !flags_o[2]);
endmodule

bind cec_rx_errpol cec_errpol_chk #(.BIT_CYCLES(BIT_CYCLES)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .rise_err_i       (rise_err_i),
  .long_err_i       (long_err_i),
  .short_err_i      (short_err_i),
  .bcast_i          (bcast_i),
  .cfg_bcast_quiet_i(cfg_bcast_quiet_i),
  .flag_clr_i       (flag_clr_i),
  .rx_abort_o       (rx_abort_o),
  .errbit_o         (errbit_o),
  .rx_hold_o        (rx_hold_o),
  .flags_o          (flags_o)
);

// File: tb/cec_rx_errpol_tb_top.sv
module cec_rx_errpol_tb_top;
  localparam int BIT_CYCLES = 16;
  localparam int ERR_LEN    = (BIT_CYCLES * 3) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rise_s = 0, long_s = 0, short_s = 0;
  logic bcast = 0, listen = 0, stop = 0, rise_en = 0, long_en = 0, quiet = 0;
  logic line = 1'b1;
  logic [2:0] clr = '0;
  logic abort_o, errbit_o, hold_o;
  logic [2:0] flags_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  cec_rx_errpol #(.BIT_CYCLES(BIT_CYCLES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rise_err_i(rise_s), .long_err_i(long_s), .short_err_i(short_s),
    .bcast_i(bcast), .full_listen_i(listen),
    .cfg_stop_on_rise_i(stop), .cfg_rise_errbit_i(rise_en),
    .cfg_long_errbit_i(long_en), .cfg_bcast_quiet_i(quiet),
    .line_i(line), .flag_clr_i(clr),
    .rx_abort_o(abort_o), .errbit_o(errbit_o), .rx_hold_o(hold_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_fault(input int kind);
    @(negedge clk);
    rise_s  = (kind == 0);
    long_s  = (kind == 1);
    short_s = (kind == 2);
    @(negedge clk);
    rise_s = 0; long_s = 0; short_s = 0;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 200 && hold_o; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 3'b111;
    @(negedge clk); clr = 3'b000;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 abort", abort_o, 0);
    check("R10 errbit", errbit_o, 0);
    check("R10 hold", hold_o, 0);
    check("R10 flags", flags_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: kind x bcast x listen x stop x rise_en x long_en x quiet
    for (int kind = 0; kind < 3; kind++) begin
      for (int c = 0; c < 64; c++) begin
        int exp_ab, exp_eb, n;
        string tag;
        bcast = c[0]; listen = c[1]; stop = c[2];
        rise_en = c[3]; long_en = c[4]; quiet = c[5];
        if (kind == 0) begin
          exp_ab = stop;
          exp_eb = bcast ? (stop & !quiet) : (stop & rise_en);
          tag = bcast ? (quiet ? "R5" : "R4") : "R2";
        end else if (kind == 1) begin
          exp_ab = 1;
          exp_eb = bcast ? !quiet : long_en;
          tag = bcast ? (quiet ? "R5" : "R4") : "R3";
        end else begin
          exp_ab = 1;
          exp_eb = !(bcast && (quiet || listen));
          tag = "R6";
        end
        pulse_fault(kind);
        check("R1 abort", abort_o, exp_ab);
        check(tag, errbit_o, exp_eb);
        check("R8 flag set", flags_o, 1 << kind);
        n = 0;
        while (errbit_o && n < 100) begin n++; @(negedge clk); end
        check("R7 errbit length", n, exp_eb ? ERR_LEN : 0);
        wait_release();
        clear_all();
        check("R8 flag clear", flags_o, 0);
      end
    end

    // R9: exact release timing and restart on a low line sample
    bcast = 0; long_en = 1; quiet = 0;
    pulse_fault(1);
    while (errbit_o) @(negedge clk);
    begin
      int h = 0;
      while (hold_o && h < 100) begin h++; @(negedge clk); end
      check("R9 release after idle", h, BIT_CYCLES);
    end
    clear_all();
    long_en = 0;
    pulse_fault(1);                      // abort without error bit
    check("R9 hold set", hold_o, 1);
    repeat (5) @(negedge clk);
    line = 1'b0;
    @(negedge clk);
    line = 1'b1;
    begin
      int h = 0;
      while (hold_o && h < 100) begin h++; @(negedge clk); end
      check("R9 restart on low line", h, BIT_CYCLES);
    end
    clear_all();

    // R9: strobes during hold are ignored
    pulse_fault(1);
    clear_all();
    check("R9 hold active", hold_o, 1);
    pulse_fault(2);
    check("R9 ignored flag", flags_o, 0);
    check("R9 ignored abort", abort_o, 0);
    check("R9 ignored errbit", errbit_o, 0);
    wait_release();

    // R8: set wins over clear in the same cycle; rise without stop keeps no hold
    stop = 0;
    @(negedge clk); rise_s = 1; clr = 3'b001;
    @(negedge clk); rise_s = 0; clr = 3'b000;
    check("R8 set beats clear", flags_o, 1);
    check("R1 no abort without stop", hold_o, 0);
    clear_all();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule